// File: doc/BRIEF.md
# Hub Status Cache

Each board on a daisy-chained control bus broadcasts its status packet in a fixed time slot after a host query. This block listens to every received packet and keeps a copy of each sender's status payload in a local store indexed by the sender's node number. Because every node keeps the whole set, any node can act as the hub. The host then fetches the status of every board with one block read, and the response builder streams the cached quadlets out of this block in node order.

A packet is delivered as a start marker with the source node and a broadcast flag, then its payload quadlets, then an end marker that carries the CRC verdict. Payload quadlets go into a staging buffer first. They are copied into the node's slot in one cycle, and only when the end marker confirms a complete, broadcast, CRC-good packet. A host query clears all per-node valid bits, so stale status from an earlier cycle is never served as fresh.

Top module: `hub_status_cache`

## Requirements
- R1: A broadcast packet with exactly QUADS payload quadlets and a good CRC, from node n < NUM_SLOTS, replaces all of slot n at the clock edge that samples its end marker. slotValid[n] reads 1 from that edge on.
- R2: With rdEn high, rdAddr = n*QUADS + q (q < QUADS) selects quadlet q of slot n, where quadlet 0 is the first payload quadlet received. rdData shows it after the next clock edge.
- R3: A packet whose end marker has rxCrcGood low changes neither the slot contents nor any valid bit.
- R4: A packet whose start marker has rxBcast low changes neither the slot contents nor any valid bit.
- R5: A packet with more or fewer than QUADS payload quadlets changes neither the slot contents nor any valid bit.
- R6: A packet whose 6-bit source node is NUM_SLOTS or above (for example 8 or 40 with 8 slots) is ignored.
- R7: A hostQuery pulse clears every slotValid bit at the next edge. If a commit happens in the same cycle, that node's bit ends set.
- R8: A read of an address of NUM_SLOTS*QUADS or above, or of a slot whose valid bit is clear, returns zero.
- R9: After reset, slotValid is all zero and rdData is zero.
- R10: A start marker that arrives before the current packet's end marker abandons that packet. Only the new packet can commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxSop | input | 1 | Start of a received packet (header cycle, no payload) |
| rxSrcNode | input | NODE_W | Source node number, valid with rxSop |
| rxBcast | input | 1 | Packet is a broadcast, valid with rxSop |
| rxQuadValid | input | 1 | rxQuad carries a payload quadlet |
| rxQuad | input | DATA_W | Payload quadlet |
| rxEop | input | 1 | End of packet (no payload) |
| rxCrcGood | input | 1 | CRC verdict, valid with rxEop |
| hostQuery | input | 1 | New host query seen; clears valid bits |
| rdEn | input | 1 | Read request |
| rdAddr | input | ADDR_W | Read address, node*QUADS + quadlet |
| rdData | output | DATA_W | Read data, one cycle after rdEn |
| slotValid | output | NUM_SLOTS | Per-node valid bits |

## Verification
The bench sweeps the whole read address range after each scenario and compares every word with an arithmetic model. An address decode that used a power-of-two stride instead of QUADS would show misplaced quadlets, and a missing range check would return data above the last slot. Rejected packets are sent with payloads unlike the cached ones, so bad CRC, unicast, short, long and out-of-range-node packets that leaked into a slot would show up as changed words or valid bits. A query and a commit in the same cycle expose a wrong priority as a missing valid bit. A packet cut short by a new start marker shows whether a design mixes the two payloads or commits the abandoned one.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
  typedef struct packed {
    logic stageWe;
    logic commitEn;
    logic clearAll;
  } hscStrobes_t;
endpackage

// File: rtl/hsc_ctrl.sv
module hsc_ctrl
  import hsc_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int QUADS     = 12,
  parameter int NODE_W    = 6,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int QIDX_W   = $clog2(QUADS),
  localparam int QCNT_W   = $clog2(QUADS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxSop,
  input  logic [NODE_W-1:0] rxSrcNode,
  input  logic              rxBcast,
  input  logic              rxQuadValid,
  input  logic              rxEop,
  input  logic              rxCrcGood,
  input  logic              hostQuery,
  output hscStrobes_t       strb,
  output logic [QIDX_W-1:0] stageIdx,
  output logic [SLOT_W-1:0] commitSlot
);
  logic              inPkt;
  logic              pktBcast;
  logic              tooLong;
  logic [NODE_W-1:0] pktNode;
  logic [QCNT_W-1:0] quadCnt;
  logic              cntFull;
  logic              slotOk;

  assign cntFull = (quadCnt == QCNT_W'(QUADS));
  assign slotOk  = ({1'b0, pktNode} < (NODE_W + 1)'(NUM_SLOTS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inPkt    <= 1'b0;
      pktBcast <= 1'b0;
      tooLong  <= 1'b0;
      pktNode  <= '0;
      quadCnt  <= '0;
    end else if (rxSop) begin
      inPkt    <= 1'b1;
      pktBcast <= rxBcast;
      pktNode  <= rxSrcNode;
      tooLong  <= 1'b0;
      quadCnt  <= '0;
    end else if (rxEop) begin
      inPkt <= 1'b0;
    end else if (inPkt && rxQuadValid) begin
      if (cntFull) tooLong <= 1'b1;
      else         quadCnt <= quadCnt + 1'b1;
    end
  end

  always_comb begin
    strb.stageWe  = inPkt && rxQuadValid && !rxSop && !rxEop && !cntFull;
    strb.commitEn = inPkt && rxEop && !rxSop && rxCrcGood && pktBcast &&
                    cntFull && !tooLong && slotOk;
    strb.clearAll = hostQuery;
    stageIdx      = QIDX_W'(quadCnt);
    commitSlot    = SLOT_W'(pktNode);
  end
endmodule

// File: rtl/hsc_datapath.sv
module hsc_datapath
  import hsc_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int QUADS     = 12,
  parameter int DATA_W    = 32,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int QIDX_W   = $clog2(QUADS),
  localparam int TOTAL    = NUM_SLOTS * QUADS,
  localparam int ADDR_W   = $clog2(TOTAL)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  hscStrobes_t          strb,
  input  logic [QIDX_W-1:0]    stageIdx,
  input  logic [SLOT_W-1:0]    commitSlot,
  input  logic [DATA_W-1:0]    rxQuad,
  input  logic                 rdEn,
  input  logic [ADDR_W-1:0]    rdAddr,
  output logic [DATA_W-1:0]    rdData,
  output logic [NUM_SLOTS-1:0] slotValid
);
  logic [DATA_W-1:0] stageBuf [QUADS];
  logic [DATA_W-1:0] cacheMem [NUM_SLOTS][QUADS];
  logic [SLOT_W-1:0] rdNode;
  logic [QIDX_W-1:0] rdOff;
  logic              rdInRange;

  always_ff @(posedge clk) begin
    if (strb.stageWe) stageBuf[stageIdx] <= rxQuad;
  end

  for (genvar q = 0; q < QUADS; q++) begin : g_slotWr
    always_ff @(posedge clk) begin
      if (strb.commitEn) cacheMem[commitSlot][q] <= stageBuf[q];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotValid <= '0;
    end else begin
      if (strb.clearAll) slotValid <= '0;
      if (strb.commitEn) slotValid[commitSlot] <= 1'b1;
    end
  end

  always_comb begin
    rdInRange = ({1'b0, rdAddr} < (ADDR_W + 1)'(TOTAL));
    rdNode    = SLOT_W'(rdAddr / ADDR_W'(QUADS));
    rdOff     = QIDX_W'(rdAddr % ADDR_W'(QUADS));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (rdEn) begin
      if (rdInRange && slotValid[rdNode]) rdData <= cacheMem[rdNode][rdOff];
      else                                rdData <= '0;
    end
  end
endmodule

// File: rtl/hub_status_cache.sv
module hub_status_cache
  import hsc_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int QUADS     = 12,
  parameter int DATA_W    = 32,
  parameter int NODE_W    = 6,
  localparam int ADDR_W   = $clog2(NUM_SLOTS * QUADS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxSop,
  input  logic [NODE_W-1:0]    rxSrcNode,
  input  logic                 rxBcast,
  input  logic                 rxQuadValid,
  input  logic [DATA_W-1:0]    rxQuad,
  input  logic                 rxEop,
  input  logic                 rxCrcGood,
  input  logic                 hostQuery,
  input  logic                 rdEn,
  input  logic [ADDR_W-1:0]    rdAddr,
  output logic [DATA_W-1:0]    rdData,
  output logic [NUM_SLOTS-1:0] slotValid
);
  localparam int SLOT_W = $clog2(NUM_SLOTS);
  localparam int QIDX_W = $clog2(QUADS);

  hscStrobes_t       strb;
  logic [QIDX_W-1:0] stageIdx;
  logic [SLOT_W-1:0] commitSlot;

  hsc_ctrl #(.NUM_SLOTS(NUM_SLOTS), .QUADS(QUADS), .NODE_W(NODE_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .rxSop(rxSop), .rxSrcNode(rxSrcNode),
    .rxBcast(rxBcast), .rxQuadValid(rxQuadValid), .rxEop(rxEop),
    .rxCrcGood(rxCrcGood), .hostQuery(hostQuery), .strb(strb),
    .stageIdx(stageIdx), .commitSlot(commitSlot)
  );

  hsc_datapath #(.NUM_SLOTS(NUM_SLOTS), .QUADS(QUADS), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .stageIdx(stageIdx),
    .commitSlot(commitSlot), .rxQuad(rxQuad), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdData), .slotValid(slotValid)
  );
endmodule

// File: rtl/hsc_chk.sv
module hsc_chk #(
  parameter int NUM_SLOTS = 8,
  parameter int QUADS     = 12,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 7
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 rxEop,
  input logic                 rxCrcGood,
  input logic                 hostQuery,
  input logic                 rdEn,
  input logic [ADDR_W-1:0]    rdAddr,
  input logic [DATA_W-1:0]    rdData,
  input logic [NUM_SLOTS-1:0] slotValid
);
  localparam int TOTAL = NUM_SLOTS * QUADS;

  // R1
  one_new_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> $countones(slotValid & ~$past(slotValid)) <= 1);

  // R1
  set_needs_eop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxEop |=> (slotValid & ~$past(slotValid)) == '0);

  // R3
  bad_crc_keeps_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxEop && !rxCrcGood && !hostQuery) |=> $stable(slotValid));

  // R7
  query_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostQuery && !rxEop) |=> slotValid == '0);

  // R8
  range_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && ({1'b0, rdAddr} >= (ADDR_W + 1)'(TOTAL))) |=> rdData == '0);

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (slotValid == '0 && rdData == '0));
endmodule

bind hub_status_cache hsc_chk #(
  .NUM_SLOTS(NUM_SLOTS), .QUADS(QUADS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) i_hsc_chk (
  .clk(clk), .rstN(rstN), .rxEop(rxEop), .rxCrcGood(rxCrcGood),
  .hostQuery(hostQuery), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
  .slotValid(slotValid)
);

// File: tb/test_hub_status_cache.sv
`timescale 1ns/1ps
module test_hub_status_cache;
  localparam int NS = 8;
  localparam int NQ = 12;
  localparam int DW = 32;
  localparam int NW = 6;
  localparam int AW = $clog2(NS * NQ);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxSop = 1'b0, rxBcast = 1'b0, rxQuadValid = 1'b0, rxEop = 1'b0;
  logic rxCrcGood = 1'b0, hostQuery = 1'b0, rdEn = 1'b0;
  logic [NW-1:0] rxSrcNode = '0;
  logic [DW-1:0] rxQuad = '0;
  logic [AW-1:0] rdAddr = '0;
  logic [DW-1:0] rdData;
  logic [NS-1:0] slotValid;

  int total = 0;
  int bad = 0;
  logic [DW-1:0] expMem [NS][NQ];
  logic [NS-1:0] expValid = '0;

  always #2.5 clk = ~clk;

  hub_status_cache #(.NUM_SLOTS(NS), .QUADS(NQ), .DATA_W(DW), .NODE_W(NW)) i_hub_status_cache (
    .clk(clk), .rstN(rstN), .rxSop(rxSop), .rxSrcNode(rxSrcNode), .rxBcast(rxBcast),
    .rxQuadValid(rxQuadValid), .rxQuad(rxQuad), .rxEop(rxEop), .rxCrcGood(rxCrcGood),
    .hostQuery(hostQuery), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .slotValid(slotValid)
  );

  function automatic logic [DW-1:0] pay(int n, int q, int s);
    return {8'(s), 8'(n), 8'(q), 8'h5A} ^ DW'(s * 32'h01010000);
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sweep(string req);
    for (int a = 0; a < (1 << AW); a++) begin
      logic [DW-1:0] e;
      @(negedge clk);
      rdEn = 1'b1;
      rdAddr = AW'(a);
      @(negedge clk);
      rdEn = 1'b0;
      if (a >= NS * NQ) e = '0;
      else if (expValid[a / NQ]) e = expMem[a / NQ][a % NQ];
      else e = '0;
      check(req, rdData, e);
    end
    check({req, " valid"}, DW'(slotValid), DW'(expValid));
  endtask

  task automatic sendHead(int node, bit bc);
    @(negedge clk);
    rxSop = 1'b1; rxSrcNode = NW'(node); rxBcast = bc;
    @(negedge clk);
    rxSop = 1'b0;
  endtask

  task automatic sendQuads(int node, int nq, int seed);
    for (int q = 0; q < nq; q++) begin
      rxQuadValid = 1'b1; rxQuad = pay(node, q, seed);
      @(negedge clk);
    end
    rxQuadValid = 1'b0;
  endtask

  task automatic sendPkt(int node, bit bc, int nq, bit crc, int seed, bit qry);
    sendHead(node, bc);
    sendQuads(node, nq, seed);
    rxEop = 1'b1; rxCrcGood = crc; hostQuery = qry;
    @(negedge clk);
    rxEop = 1'b0; rxCrcGood = 1'b0; hostQuery = 1'b0;
    if (qry) expValid = '0;
    if (bc && crc && nq == NQ && node < NS) begin
      for (int q = 0; q < NQ; q++) expMem[node][q] = pay(node, q, seed);
      expValid[node] = 1'b1;
    end
  endtask

  task automatic query();
    @(negedge clk);
    hostQuery = 1'b1;
    @(negedge clk);
    hostQuery = 1'b0;
    expValid = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 valid", DW'(slotValid), '0);
    check("R9 rdData", rdData, '0);
    rstN = 1'b1;
    sweep("R9 R8 empty");

    // R1 R2 fill every slot, in scrambled order
    for (int i = 0; i < NS; i++) sendPkt((i * 5) % NS, 1'b1, NQ, 1'b1, 1, 1'b0);
    sweep("R1 R2 fill");

    // R3 bad CRC
    sendPkt(3, 1'b1, NQ, 1'b0, 7, 1'b0);
    sweep("R3 bad crc");

    // R4 unicast
    sendPkt(4, 1'b0, NQ, 1'b1, 8, 1'b0);
    sweep("R4 unicast");

    // R5 wrong length
    sendPkt(5, 1'b1, NQ - 1, 1'b1, 9, 1'b0);
    sendPkt(5, 1'b1, NQ + 1, 1'b1, 10, 1'b0);
    sweep("R5 length");

    // R6 out-of-range node
    sendPkt(NS, 1'b1, NQ, 1'b1, 11, 1'b0);
    sendPkt(40, 1'b1, NQ, 1'b1, 12, 1'b0);
    sweep("R6 node range");

    // R7 R8 query clears, invalid slots read zero
    query();
    sweep("R7 R8 query");

    // R1 overwrite, then R7 query with commit same cycle
    sendPkt(2, 1'b1, NQ, 1'b1, 20, 1'b0);
    sendPkt(6, 1'b1, NQ, 1'b1, 21, 1'b1);
    sweep("R7 query+commit");

    // R10 restart mid-packet
    sendHead(1, 1'b1);
    sendQuads(1, 5, 30);
    sendPkt(0, 1'b1, NQ, 1'b1, 31, 1'b0);
    sweep("R10 restart");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule